// File: doc/BRIEF.md
# Line Loss-of-Signal and Clock-Activity Monitor

This block raises the line alarms of a timing-recovery receiver. In the recovered clock domain it counts consecutive zero bits on the received NRZ data. It asserts loss of signal once the run reaches a threshold that depends on the line mode: one threshold for 1.544 Mbit/s lines, one for 2.048 Mbit/s lines, and a long, parameterized count for the 6312 kHz synchronization mode. A sticky change-of-state flag records every rise and every fall of that alarm, and software clears it with a write-one-to-clear pulse.

In the master clock domain a watchdog samples the external transmit clock through a synchronizer. It measures quiet time in periods of a prescaled master clock and flags loss of transmit clock when no edge arrives for a set number of those periods. One shared status output reports either the incoming loss-of-frame indication or the loss-of-transmit-clock flag, as a select input chooses. In the 6312 kHz mode that output is forced low and its output enable is dropped.

Top module: `line_alarm_monitor`

## Requirements
- R1: With `mode_i` = 2'b00, `los_o` goes high at the clock edge that samples the T1_RUN-th consecutive zero (default 192) and not before.
- R2: With `mode_i` = 2'b01, `los_o` goes high at the edge that samples the E1_RUN-th consecutive zero (default 255) and not before.
- R3: With `mode_i` = 2'b10 or 2'b11 (6312 kHz mode), `los_o` goes high at the edge that samples the SYNC_RUN-th consecutive zero.
- R4: A sampled one drops `los_o` at that same edge, and the zero run then restarts from zero.
- R5: The zero counter saturates and does not wrap, so `los_o` stays high for any length of zero run beyond the threshold.
- R6: With no transmit clock edge, the loss-of-transmit-clock flag rises between LIMIT*PRESCALE-PRESCALE+4 and LIMIT*PRESCALE+3 master clock cycles after the last edge of `tclk_i` is presented. These are cycles 60 to 63 for the defaults, which include the 3-cycle synchronizer and edge-detect delay.
- R7: Any synchronized edge of `tclk_i` clears the loss-of-transmit-clock flag and restarts its timer.
- R8: In modes 2'b00 and 2'b01, `share_o` equals `lof_i` when `share_sel_i` = 0 and equals the loss-of-transmit-clock flag when `share_sel_i` = 1.
- R9: In modes 2'b10 and 2'b11, `share_o` = 0 and `share_oe_o` = 0. In modes 2'b00 and 2'b01, `share_oe_o` = 1.
- R10: `los_cos_o` goes high one recovered-clock edge after any change of `los_o`, and it then stays high.
- R11: A high `cos_clr_i` clears `los_cos_o` at the next edge. If a change of `los_o` is being recorded at that same edge, the set takes priority.
- R12: While `rst_ni` is low, `los_o`, `los_cos_o` and the loss-of-transmit-clock flag are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rx_i | input | 1 | Recovered line clock |
| clk_m_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Line mode: 00 T1, 01 E1, 1x 6312 kHz |
| rx_data_i | input | 1 | Received NRZ data, sampled on clk_rx_i |
| tclk_i | input | 1 | External transmit clock, asynchronous |
| lof_i | input | 1 | Receive loss-of-frame indication |
| share_sel_i | input | 1 | 0: share_o reports lof_i; 1: reports loss of transmit clock |
| cos_clr_i | input | 1 | Write-one-to-clear pulse for los_cos_o (clk_rx_i domain) |
| los_o | output | 1 | Loss of signal |
| los_cos_o | output | 1 | Sticky change-of-state flag of los_o |
| share_o | output | 1 | Shared loss-of-frame / loss-of-transmit-clock status |
| share_oe_o | output | 1 | Output enable of share_o |

## Verification
Some properties are checked by assertions on every cycle. The zero counter never passes its largest threshold. A sampled one always drops the alarm, and the alarm holds while zeros continue. A transmit clock edge always clears the watchdog flag. The watchdog flag is only up when its timer is full. The change-of-state flag sets after every alarm change and clears on a lone clear pulse. Other behaviour can only be shown by the bench scenarios. These include the exact edge on which each mode's threshold trips, the effect of a mode change on the threshold, the timeout window measured from the last transmit clock edge, and the routing and enable of the shared output in each mode.

// File: rtl/lam_pkg.sv
package lam_pkg;

  typedef enum logic [1:0] {
    MODE_T1       = 2'b00,
    MODE_E1       = 2'b01,
    MODE_SYNC     = 2'b10,
    MODE_SYNC_ALT = 2'b11
  } line_mode_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/lam_zero_run.sv
module lam_zero_run
  import lam_pkg::*;
#(
  parameter int unsigned T1_RUN   = 192,
  parameter int unsigned E1_RUN   = 255,
  parameter int unsigned SYNC_RUN = 409600,
  parameter int unsigned CW       = 19
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       data_i,
  output logic       los_o
);

  localparam int unsigned MAX_RUN = max3(T1_RUN, E1_RUN, SYNC_RUN);
  localparam logic [CW-1:0] T1_THR   = CW'(T1_RUN);
  localparam logic [CW-1:0] E1_THR   = CW'(E1_RUN);
  localparam logic [CW-1:0] SYNC_THR = CW'(SYNC_RUN);
  localparam logic [CW-1:0] MAX_THR  = CW'(MAX_RUN);

  logic [CW-1:0] thr, cnt_q, cnt_n;
  logic          los_q;

  always_comb begin
    case (mode_i)
      MODE_T1: thr = T1_THR;
      MODE_E1: thr = E1_THR;
      default: thr = SYNC_THR;
    endcase
  end

  // saturate at the active threshold; a one restarts the run
  always_comb begin
    if (data_i)           cnt_n = '0;
    else if (cnt_q >= thr) cnt_n = cnt_q;
    else                  cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      los_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      los_q <= !data_i && (cnt_n >= thr);
    end
  end

  assign los_o = los_q;

  assert_cnt_saturates_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= MAX_THR);

  assert_one_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_i |=> !los_q);

  assert_hold_on_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (los_q && !data_i && $stable(mode_i)) |=> los_q);

endmodule

// File: rtl/lam_clk_watchdog.sv
module lam_clk_watchdog #(
  parameter int unsigned PRESCALE = 4,
  parameter int unsigned LIMIT    = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tclk_i,
  output logic lost_o
);

  localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int unsigned LW = $clog2(LIMIT + 1);
  localparam logic [LW-1:0] LIM = LW'(LIMIT);

  logic [2:0]    sync_q;
  logic          edge_seen;
  logic          tick;
  logic [LW-1:0] cnt_q;
  logic          lost_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], tclk_i};
  end

  assign edge_seen = sync_q[1] ^ sync_q[2];

  generate
    if (PRESCALE > 1) begin : g_div
      localparam logic [PW-1:0] DIV_END = PW'(PRESCALE - 1);
      logic [PW-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)             div_q <= '0;
        else if (div_q == DIV_END) div_q <= '0;
        else                     div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == DIV_END);
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lost_q <= 1'b0;
    end else if (edge_seen) begin
      cnt_q  <= '0;
      lost_q <= 1'b0;
    end else if (tick && (cnt_q < LIM)) begin
      cnt_q  <= cnt_q + 1'b1;
      lost_q <= lost_q | (cnt_q == LIM - 1'b1);
    end
  end

  assign lost_o = lost_q;

  assert_edge_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_seen |=> (!lost_q && cnt_q == '0));

  assert_lost_needs_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_q |-> (cnt_q == LIM));

endmodule

// File: rtl/lam_cos_latch.sv
module lam_cos_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic los_i,
  input  logic clr_i,
  output logic cos_o
);

  logic los_prev_q, flag_q, set;

  assign set = los_i ^ los_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      los_prev_q <= 1'b0;
      flag_q     <= 1'b0;
    end else begin
      los_prev_q <= los_i;
      flag_q     <= set | (flag_q & ~clr_i); // set beats clear
    end
  end

  assign cos_o = flag_q;

  assert_set_on_change_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (los_i != los_prev_q) |=> flag_q);

  assert_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set) |=> !flag_q);

endmodule

// File: rtl/line_alarm_monitor.sv
module line_alarm_monitor
  import lam_pkg::*;
#(
  parameter int unsigned T1_RUN   = 192,
  parameter int unsigned E1_RUN   = 255,
  parameter int unsigned SYNC_RUN = 409600,
  parameter int unsigned PRESCALE = 4,
  parameter int unsigned LIMIT    = 15
) (
  input  logic       clk_rx_i,
  input  logic       clk_m_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       rx_data_i,
  input  logic       tclk_i,
  input  logic       lof_i,
  input  logic       share_sel_i,
  input  logic       cos_clr_i,
  output logic       los_o,
  output logic       los_cos_o,
  output logic       share_o,
  output logic       share_oe_o
);

  localparam int unsigned CW = $clog2(max3(T1_RUN, E1_RUN, SYNC_RUN) + 1);

  logic los, lotc, sync_mode;

  lam_zero_run #(
    .T1_RUN  (T1_RUN),
    .E1_RUN  (E1_RUN),
    .SYNC_RUN(SYNC_RUN),
    .CW      (CW)
  ) u_zero_run (
    .clk_i (clk_rx_i),
    .rst_ni(rst_ni),
    .mode_i(mode_i),
    .data_i(rx_data_i),
    .los_o (los)
  );

  lam_cos_latch u_cos (
    .clk_i (clk_rx_i),
    .rst_ni(rst_ni),
    .los_i (los),
    .clr_i (cos_clr_i),
    .cos_o (los_cos_o)
  );

  lam_clk_watchdog #(
    .PRESCALE(PRESCALE),
    .LIMIT   (LIMIT)
  ) u_watchdog (
    .clk_i (clk_m_i),
    .rst_ni(rst_ni),
    .tclk_i(tclk_i),
    .lost_o(lotc)
  );

  assign sync_mode  = (mode_i == MODE_SYNC) || (mode_i == MODE_SYNC_ALT);
  assign los_o      = los;
  assign share_oe_o = !sync_mode;
  assign share_o    = !sync_mode && (share_sel_i ? lotc : lof_i);

endmodule

// File: tb/line_alarm_monitor_tb_top.sv
`timescale 1ns/1ps
module line_alarm_monitor_tb_top;

  localparam int unsigned T1R = 192;
  localparam int unsigned E1R = 255;
  localparam int unsigned SYR = 300;
  localparam int unsigned PS  = 4;
  localparam int unsigned LIM = 15;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       rx = 1'b1, tclk = 1'b0, lof = 1'b0, sel = 1'b0, clr = 1'b0;
  logic       los, cos, shr, shr_oe;

  int checks = 0, errors = 0;
  int run = 0, thr = T1R, step_no = 0;
  bit l1 = 0, l2 = 0, ecos = 0;

  always #2.5 clk = ~clk;

  line_alarm_monitor #(
    .T1_RUN(T1R), .E1_RUN(E1R), .SYNC_RUN(SYR), .PRESCALE(PS), .LIMIT(LIM)
  ) dut_i (
    .clk_rx_i(clk), .clk_m_i(clk), .rst_ni(rst_ni), .mode_i(mode),
    .rx_data_i(rx), .tclk_i(tclk), .lof_i(lof), .share_sel_i(sel),
    .cos_clr_i(clr), .los_o(los), .los_cos_o(cos), .share_o(shr),
    .share_oe_o(shr_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int thr_of(input logic [1:0] m);
    return (m == 2'b00) ? T1R : (m == 2'b01) ? E1R : SYR;
  endfunction

  function automatic string mode_tag(input logic [1:0] m);
    return (m == 2'b00) ? "R1" : (m == 2'b01) ? "R2" : "R3";
  endfunction

  // one recovered-clock bit; reference model updated and compared after the edge
  task automatic step(input bit b, input bit c);
    bit nlos, ncos;
    string lt, ct;
    @(negedge clk);
    rx = b; clr = c;
    @(posedge clk); #1;
    run  = b ? 0 : run + 1;
    nlos = (run >= thr);
    ncos = (l1 != l2) | (ecos & ~c);
    lt = b ? "R4" : (run > thr) ? "R5" : mode_tag(mode);
    ct = (c && (l1 != l2)) ? "R11" : c ? "R11" : "R10";
    chk(los == nlos, lt, los, nlos);
    chk(cos == ncos, ct, cos, ncos);
    l2 = l1; l1 = nlos; ecos = ncos;
    step_no++;
  endtask

  task automatic sweep_mode(input logic [1:0] m);
    int lens[5];
    step(1'b1, 1'b0);
    @(negedge clk); mode = m; thr = thr_of(m);
    lens = '{1, thr - 1, thr, thr + 1, thr + 4};
    foreach (lens[k]) begin
      for (int i = 0; i < lens[k]; i++) step(1'b0, (step_no % 11) == 5);
      step(1'b1, (step_no % 11) == 5);
      step(1'b1, (step_no % 11) == 5);
    end
  endtask

  initial begin
    int n;
    bit seen;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(los == 1'b0, "R12", los, 0);
    chk(cos == 1'b0, "R12", cos, 0);
    sel = 1'b1; #1;
    chk(shr == 1'b0, "R12", shr, 0);
    sel = 1'b0;
    @(negedge clk); rst_ni = 1'b1;

    sweep_mode(2'b00);
    sweep_mode(2'b01);
    sweep_mode(2'b10);
    sweep_mode(2'b11);

    // R11 directed: clear in the cycle a change is recorded
    step(1'b1, 1'b1);
    @(negedge clk); mode = 2'b00; thr = T1R;
    step(1'b1, 1'b1);
    for (int i = 0; i < T1R; i++) step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    chk(cos == 1'b1, "R11", cos, 1);
    step(1'b0, 1'b1);
    chk(cos == 1'b0, "R11", cos, 0);
    step(1'b1, 1'b0);

    // R8: shared output routes lof_i
    @(negedge clk); mode = 2'b00; sel = 1'b0;
    for (int i = 0; i < 4; i++) begin
      lof = i[0]; #1;
      chk(shr == lof, "R8", shr, lof);
      chk(shr_oe == 1'b1, "R9", shr_oe, 1);
    end
    @(negedge clk); mode = 2'b01; lof = 1'b1; #1;
    chk(shr == 1'b1, "R8", shr, 1);
    lof = 1'b0;

    // R7: toggling transmit clock keeps the flag low; R8 with sel=1
    sel = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (i % 3 == 0) tclk = ~tclk;
      if (i >= 6) chk(shr == 1'b0, "R7", shr, 0);
    end
    // R6: timeout window measured from the last toggle (i=27)
    n = 2; seen = 0;
    while (!seen && n < 200) begin
      @(negedge clk); n++;
      if (shr) seen = 1;
    end
    chk(seen && n >= int'(LIM * PS - PS + 4) && n <= int'(LIM * PS + 3), "R6",
        n, LIM * PS);
    chk(shr == 1'b1, "R8", shr, 1);

    // R9: 6312 kHz mode forces output low and disables it
    lof = 1'b1;
    for (int m = 2; m < 4; m++) begin
      for (int s = 0; s < 2; s++) begin
        @(negedge clk); mode = 2'(m); sel = s[0]; #1;
        chk(shr == 1'b0, "R9", shr, 0);
        chk(shr_oe == 1'b0, "R9", shr_oe, 0);
      end
    end

    // R7: one edge clears the flag
    @(negedge clk); mode = 2'b00; sel = 1'b1; tclk = ~tclk;
    repeat (5) @(negedge clk);
    chk(shr == 1'b0, "R7", shr, 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule